// File: doc/BRIEF.md
# Dual-Port Receiver Input Scanner

This block picks which of two receiver inputs is active. Only one input is live at a time. After reset the first input is selected. The block then waits for a source on that input. If the synchronised signal-detect line stays low for the whole dwell time (three seconds by default, worked out from the clock frequency), the block moves to the other input and starts waiting again. This repeats until a source shows up.

Once signal-detect has been high for a set number of cycles in a row, the block holds its current input and raises a locked flag. If the detect line falls, the lock is dropped and the dwell timer starts again from zero on the same input.

Both hot-plug enables are active low. They are held high (disabled) in reset and driven low from the first clock after reset. The EDID write-protect output is tied high so that an attached source can read EDID. The host uses the port index and the switch pulse to steer the receiver's own input mux.

Top module: `rx_port_scanner`

## Requirements
- R1: While the synchronous active-low reset is asserted:
  - `port_sel` is 0 (first input).
  - `locked` and `port_switch` are 0.
  - `hpd_n` is 2'b11.
- R2: From the first clock edge after reset is released, `hpd_n` is 2'b00 and stays there until the next reset.
- R3: `port_sel` toggles between 0 and 1 after DWELL_CYCLES = CLK_HZ*DWELL_SEC consecutive clock edges on which the synchronised detect is low. With no source at all, the first toggle happens on the DWELL_CYCLES-th edge after reset is released.
- R4: `port_switch` is high for exactly the one cycle in which `port_sel` has just changed, and is low at all other times.
- R5: `sig_det` is asynchronous and passes through two flops before any decision uses it. A rise on `sig_det` sampled at edge k is first acted on at edge k+2.
- R6: `locked` rises only after LOCK_CYCLES consecutive edges with the synchronised detect high. A shorter pulse never sets it.
- R7: While the synchronised detect is high, `port_sel` does not change. This holds even when detect arrives on the same edge on which the dwell would have expired.
- R8: When the synchronised detect goes low, `locked` clears on that edge and the dwell count restarts from zero on the current port. The next switch happens DWELL_CYCLES edges later.
- R9: `edid_wp` is high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sig_det | input | 1 | Asynchronous signal-present indication for the selected input |
| port_sel | output | 1 | Active input index: 0 is the first input, 1 is the second |
| locked | output | 1 | Source qualified on the active input |
| port_switch | output | 1 | One-cycle pulse on every change of `port_sel` |
| hpd_n | output | 2 | Per-input hot-plug enables, active low |
| edid_wp | output | 1 | EDID write protect, held high |

## Verification
Dwell expiry and detect arrival can fall on the same clock edge. When they do, the detect must win: the port stays put and no pulse is produced. The bench uses its own reference model's dwell count to drive `sig_det` three edges ahead, so that the synchronised detect lands exactly on the expiry edge. It then checks that `port_sel` and `port_switch` do not move. A detect drop after lock is also checked, to confirm the dwell restarts with a full window.

// File: rtl/rx_port_scanner.sv
module rx_port_scanner #(
  parameter int CLK_HZ      = 27_000_000,
  parameter int DWELL_SEC   = 3,
  parameter int LOCK_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sig_det,
  output logic       port_sel,
  output logic       locked,
  output logic       port_switch,
  output logic [1:0] hpd_n,
  output logic       edid_wp
);
  localparam int DWELL_CYCLES = CLK_HZ * DWELL_SEC;
  localparam int DW = $clog2(DWELL_CYCLES + 1);
  localparam int QW = $clog2(LOCK_CYCLES + 1);

  logic [1:0]    sync_q;
  logic [DW-1:0] dwell_q;
  logic [QW-1:0] qual_q;

  wire det     = sync_q[1];
  wire expire  = !det && (dwell_q == DW'(DWELL_CYCLES - 1));
  wire qualify = det && (qual_q == QW'(LOCK_CYCLES - 1));

  assign edid_wp = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q      <= '0;
      dwell_q     <= '0;
      qual_q      <= '0;
      port_sel    <= 1'b0;
      locked      <= 1'b0;
      port_switch <= 1'b0;
      hpd_n       <= 2'b11;
    end else begin
      sync_q      <= {sync_q[0], sig_det};
      hpd_n       <= 2'b00;
      port_switch <= expire;
      if (det) begin
        dwell_q <= '0;
        if (qual_q != QW'(LOCK_CYCLES)) qual_q <= qual_q + 1'b1;
        if (qualify) locked <= 1'b1;
      end else begin
        qual_q <= '0;
        locked <= 1'b0;
        if (expire) begin
          dwell_q  <= '0;
          port_sel <= ~port_sel;
        end else begin
          dwell_q <= dwell_q + 1'b1;
        end
      end
    end
  end

  p_hpd_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> hpd_n == 2'b00);

  p_pulse_on_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
    port_switch |-> port_sel != $past(port_sel));

  p_no_silent_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !port_switch) |-> $stable(port_sel));

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    port_switch |=> !port_switch);

  p_locked_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> !port_switch);

  p_wp_high_r9: assert property (@(posedge clk) edid_wp);
endmodule

// File: tb/test_rx_port_scanner.sv
module test_rx_port_scanner;
  localparam int HZ = 10;
  localparam int SEC = 3;
  localparam int LK = 4;
  localparam int D = HZ * SEC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sig_det = 1'b0;
  logic port_sel, locked, port_switch, edid_wp;
  logic [1:0] hpd_n;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit started = 1'b0;
  bit done = 1'b0;

  int m_s1 = 0, m_s2 = 0, m_port = 0, m_lock = 0, m_sw = 0, m_dwell = 0, m_q = 0, m_hpd = 3;

  rx_port_scanner #(.CLK_HZ(HZ), .DWELL_SEC(SEC), .LOCK_CYCLES(LK)) i_rx_port_scanner (
    .clk(clk), .rst_n(rst_n), .sig_det(sig_det), .port_sel(port_sel),
    .locked(locked), .port_switch(port_switch), .hpd_n(hpd_n), .edid_wp(edid_wp));

  always #5 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int det;
    started = 1'b1;
    cycles++;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_port = 0; m_lock = 0; m_sw = 0; m_dwell = 0; m_q = 0; m_hpd = 3;
    end else begin
      det = m_s2;
      m_s2 = m_s1;
      m_s1 = int'(sig_det);
      m_hpd = 0;
      m_sw = 0;
      if (det != 0) begin
        m_dwell = 0;
        if (m_q == LK - 1) m_lock = 1;
        if (m_q < LK) m_q++;
      end else begin
        m_q = 0;
        m_lock = 0;
        if (m_dwell == D - 1) begin
          m_dwell = 0; m_port ^= 1; m_sw = 1;
        end else m_dwell++;
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      check("R3", "port_sel", int'(port_sel), m_port);
      check("R4", "port_switch", int'(port_switch), m_sw);
      check("R6", "locked", int'(locked), m_lock);
      check("R2", "hpd_n", int'(hpd_n), m_hpd);
      check("R9", "edid_wp", int'(edid_wp), 1);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    step(3);
    check("R1", "reset port", int'(port_sel), 0);
    check("R1", "reset hpd", int'(hpd_n), 3);
    check("R1", "reset locked", int'(locked), 0);
    check("R1", "reset pulse", int'(port_switch), 0);
    rst_n = 1'b1;
    step(1);
    check("R2", "hpd after release", int'(hpd_n), 0);
    step(D - 2);
    check("R3", "port before dwell", int'(port_sel), 0);
    step(1);
    check("R3", "port after dwell", int'(port_sel), 1);
    check("R4", "pulse at switch", int'(port_switch), 1);
    step(1);
    check("R4", "pulse one cycle", int'(port_switch), 0);
    step(D);
    check("R3", "second switch", int'(port_sel), 0);
    // short glitch must not lock (R6)
    step(5);
    sig_det = 1'b1; step(LK - 1); sig_det = 1'b0;
    step(8);
    check("R6", "glitch no lock", int'(locked), 0);
    // sync latency and qualification (R5, R6)
    sig_det = 1'b1;
    step(LK + 1);
    check("R5", "lock not before sync+qual", int'(locked), 0);
    step(1);
    check("R6", "lock after qual", int'(locked), 1);
    begin
      int p;
      p = int'(port_sel);
      step(3 * D);
      check("R7", "port held while detected", int'(port_sel), p);
      check("R7", "still locked", int'(locked), 1);
    end
    // drop: lock clears, dwell restarts (R8)
    sig_det = 1'b0;
    step(3);
    check("R8", "lock cleared", int'(locked), 0);
    begin
      int p;
      p = int'(port_sel);
      step(D - 2);
      check("R8", "no early switch", int'(port_sel), p);
      step(1);
      check("R8", "switch after full dwell", int'(port_sel), 1 - p);
    end
    // coincidence: detect lands on expiry edge (R7)
    while (m_dwell != D - 3) step(1);
    begin
      int p;
      p = int'(port_sel);
      sig_det = 1'b1;
      step(3);
      check("R7", "detect beats expiry port", int'(port_sel), p);
      check("R7", "detect beats expiry pulse", int'(port_switch), 0);
      step(D);
      check("R7", "still held", int'(port_sel), p);
    end
    sig_det = 1'b0;
    step(D + 10);
    rst_n = 1'b0;
    step(2);
    check("R1", "re-reset port", int'(port_sel), 0);
    check("R1", "re-reset hpd", int'(hpd_n), 3);
    rst_n = 1'b1;
    step(5);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule